// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits in the data path of a converter's output stage, between the sample source and the serializer. With no pattern enabled it passes the 16-bit sample word through, reduced to the selected output format. When a pattern enable is set, the sample is replaced by a known pattern so that a receiver can find word and bit boundaries on its serial links. The patterns are a free-running ramp, a constant custom code, two custom codes that alternate, an alternating-bit deskew word, and a half-ones/half-zeros sync word.

There are three output formats: a 12-bit word, a 14-bit word, or two 8-bit lanes A and B. A 16-bit sample or custom code is fitted to the format by dropping bits from the LSB side. All outputs are registered, so there is one cycle of latency from the inputs to the outputs. A flag shows when a pattern is replacing the sample data.

Top module: `adc_pat_gen`

## Requirements
- R1: While rst_ni is low, word_o, lane_a_o, lane_b_o and pat_active_o are all zero.
- R2: With no enable set, one clock after the input the outputs carry sample_i. For fmt_i=0 (12-bit) or 3 (treated as 12-bit), word_o[11:0]=sample_i[15:4]. For fmt_i=1 (14-bit), word_o=sample_i[15:2]. For fmt_i=2 (dual 8-bit), lane_a_o=sample_i[15:8] and lane_b_o=sample_i[7:0].
- R3: In the first cycle in which ramp mode is the selected mode, the output is 0. The output then increases by one in each following cycle.
- R4: After the full-scale code (4095 for 12-bit, 16383 for 14-bit, 255 for dual 8-bit), the ramp returns to 0. In dual 8-bit format, both lanes carry the same ramp value.
- R5: In single custom mode, code1_i replaces the sample and is mapped to the format in the same way as in R2.
- R6: In dual custom mode, the output shows code1_i in the first selected cycle and then alternates between code2_i and code1_i every cycle. Each code is mapped as in R2.
- R7: Deskew mode outputs alternating bits with the MSB zero: 0x555 (12-bit), 0x1555 (14-bit), or 0x55 on both lanes (dual 8-bit).
- R8: Sync mode outputs ones in the upper half and zeros in the lower half: 0xFC0 (12-bit), 0x3F80 (14-bit), or 0xF0 on both lanes (dual 8-bit).
- R9: When several enables are set, the winner is chosen in this order: deskew, then sync, then ramp, then dual custom, then single custom.
- R10: One clock after the inputs, pat_active_o is 1 when any enable is set and 0 otherwise.
- R11: A mode that is left for at least one cycle and then selected again restarts: the ramp starts again at 0, and the dual custom sequence starts again at code1_i.
- R12: In dual 8-bit format word_o is zero. In the 12-bit and 14-bit formats lane_a_o and lane_b_o are zero, and word_o bits above the format width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Normal sample word, left-justified |
| fmt_i | input | 2 | Output format: 0 = 12-bit, 1 = 14-bit, 2 = dual 8-bit, 3 = 12-bit |
| ramp_en_i | input | 1 | Ramp pattern enable |
| single_en_i | input | 1 | Constant custom code enable |
| dual_en_i | input | 1 | Alternating custom codes enable |
| deskew_en_i | input | 1 | Alternating-bit pattern enable |
| sync_en_i | input | 1 | Half-ones/half-zeros pattern enable |
| code1_i | input | 16 | First custom code |
| code2_i | input | 16 | Second custom code |
| word_o | output | 14 | Output word, right-aligned to the format width |
| lane_a_o | output | 8 | Lane A in dual 8-bit format |
| lane_b_o | output | 8 | Lane B in dual 8-bit format |
| pat_active_o | output | 1 | A test pattern is replacing the sample |

## Verification
The hardest cases to reach from the ports are the ramp wraps, above all the 14-bit wrap, which needs more than sixteen thousand cycles of uninterrupted ramp. The stimulus therefore holds the ramp enable for a full period in each format. The restart cases are also hard to reach. To reach them, the stimulus leaves ramp or dual mode for a single cycle, or hands over briefly to a higher-priority mode, and then returns. A random phase then mixes enables, formats and codes, and changes the format while a ramp is running. A behavioural model follows every cycle of this.

// File: rtl/adc_pat_pkg.sv
package adc_pat_pkg;
  typedef enum logic [1:0] {
    FMT_12  = 2'd0,
    FMT_14  = 2'd1,
    FMT_D8  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    MODE_NONE   = 3'd0,
    MODE_SINGLE = 3'd1,
    MODE_DUAL   = 3'd2,
    MODE_RAMP   = 3'd3,
    MODE_SYNC   = 3'd4,
    MODE_DESKEW = 3'd5
  } mode_e;
endpackage

// File: rtl/adc_pat_mode_sel.sv
module adc_pat_mode_sel
  import adc_pat_pkg::*;
(
  input  logic  deskew_en_i,
  input  logic  sync_en_i,
  input  logic  ramp_en_i,
  input  logic  dual_en_i,
  input  logic  single_en_i,
  output mode_e mode_o
);
  // fixed priority, deskew highest
  always_comb begin
    if (deskew_en_i)      mode_o = MODE_DESKEW;
    else if (sync_en_i)   mode_o = MODE_SYNC;
    else if (ramp_en_i)   mode_o = MODE_RAMP;
    else if (dual_en_i)   mode_o = MODE_DUAL;
    else if (single_en_i) mode_o = MODE_SINGLE;
    else                  mode_o = MODE_NONE;
  end
endmodule

// File: rtl/adc_pat_seq.sv
module adc_pat_seq
  import adc_pat_pkg::*;
#(
  parameter int NARROW_W = 12,
  parameter int WIDE_W   = 14,
  parameter int LANE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  mode_e             prev_mode_i,
  input  fmt_e              fmt_i,
  output logic [WIDE_W-1:0] ramp_o,
  output logic              use_code2_o
);
  logic [WIDE_W-1:0] ramp_q;
  logic              tog_q;
  logic [WIDE_W-1:0] mask;

  always_comb begin
    case (fmt_i)
      FMT_14:  mask = '1;
      FMT_D8:  mask = {{(WIDE_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
      default: mask = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endcase
  end

  // restart whenever the mode was not selected on the previous cycle
  always_comb begin
    ramp_o      = (prev_mode_i == MODE_RAMP) ? ((ramp_q + WIDE_W'(1)) & mask) : '0;
    use_code2_o = (prev_mode_i == MODE_DUAL) && !tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ramp_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (mode_i == MODE_RAMP) ramp_q <= ramp_o;
      if (mode_i == MODE_DUAL) tog_q  <= use_code2_o;
    end
  end
endmodule

// File: rtl/adc_pat_format.sv
module adc_pat_format
  import adc_pat_pkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int NARROW_W = 12,
  parameter int WIDE_W   = 14,
  parameter int LANE_W   = 8
) (
  input  mode_e             mode_i,
  input  fmt_e              fmt_i,
  input  logic [CODE_W-1:0] sample_i,
  input  logic [CODE_W-1:0] code1_i,
  input  logic [CODE_W-1:0] code2_i,
  input  logic              use_code2_i,
  input  logic [WIDE_W-1:0] ramp_i,
  output logic [WIDE_W-1:0] word_o,
  output logic [LANE_W-1:0] lane_a_o,
  output logic [LANE_W-1:0] lane_b_o
);
  function automatic logic [WIDE_W-1:0] deskew_pat(int n);
    logic [WIDE_W-1:0] r;
    r = '0;
    for (int i = 0; i < WIDE_W; i++)
      if (i < n) r[i] = ((n - 1 - i) % 2) == 1;
    return r;
  endfunction

  function automatic logic [WIDE_W-1:0] sync_pat(int n);
    logic [WIDE_W-1:0] r;
    r = '0;
    for (int i = 0; i < WIDE_W; i++)
      if (i < n && i >= n / 2) r[i] = 1'b1;
    return r;
  endfunction

  localparam logic [WIDE_W-1:0] DSK_N  = deskew_pat(NARROW_W);
  localparam logic [WIDE_W-1:0] DSK_W  = deskew_pat(WIDE_W);
  localparam logic [WIDE_W-1:0] DSK_L  = deskew_pat(LANE_W);
  localparam logic [WIDE_W-1:0] SYN_N  = sync_pat(NARROW_W);
  localparam logic [WIDE_W-1:0] SYN_W  = sync_pat(WIDE_W);
  localparam logic [WIDE_W-1:0] SYN_L  = sync_pat(LANE_W);
  localparam int                PAD_N  = WIDE_W - NARROW_W;

  logic [CODE_W-1:0] src;

  always_comb begin
    case (mode_i)
      MODE_SINGLE: src = code1_i;
      MODE_DUAL:   src = use_code2_i ? code2_i : code1_i;
      default:     src = sample_i;
    endcase
  end

  always_comb begin
    word_o   = '0;
    lane_a_o = '0;
    lane_b_o = '0;
    case (fmt_i)
      FMT_D8: begin
        case (mode_i)
          MODE_RAMP: begin
            lane_a_o = ramp_i[LANE_W-1:0];
            lane_b_o = ramp_i[LANE_W-1:0];
          end
          MODE_DESKEW: begin
            lane_a_o = DSK_L[LANE_W-1:0];
            lane_b_o = DSK_L[LANE_W-1:0];
          end
          MODE_SYNC: begin
            lane_a_o = SYN_L[LANE_W-1:0];
            lane_b_o = SYN_L[LANE_W-1:0];
          end
          default: begin
            lane_a_o = src[CODE_W-1 -: LANE_W];
            lane_b_o = src[LANE_W-1:0];
          end
        endcase
      end
      FMT_14: begin
        case (mode_i)
          MODE_RAMP:   word_o = ramp_i;
          MODE_DESKEW: word_o = DSK_W;
          MODE_SYNC:   word_o = SYN_W;
          default:     word_o = src[CODE_W-1 -: WIDE_W];
        endcase
      end
      default: begin
        case (mode_i)
          MODE_RAMP:   word_o = ramp_i;
          MODE_DESKEW: word_o = DSK_N;
          MODE_SYNC:   word_o = SYN_N;
          default:     word_o = {{PAD_N{1'b0}}, src[CODE_W-1 -: NARROW_W]};
        endcase
      end
    endcase
  end
endmodule

// File: rtl/adc_pat_gen.sv
module adc_pat_gen
  import adc_pat_pkg::*;
#(
  parameter int CODE_W   = 16,
  parameter int NARROW_W = 12,
  parameter int WIDE_W   = 14,
  parameter int LANE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] sample_i,
  input  logic [1:0]        fmt_i,
  input  logic              ramp_en_i,
  input  logic              single_en_i,
  input  logic              dual_en_i,
  input  logic              deskew_en_i,
  input  logic              sync_en_i,
  input  logic [CODE_W-1:0] code1_i,
  input  logic [CODE_W-1:0] code2_i,
  output logic [WIDE_W-1:0] word_o,
  output logic [LANE_W-1:0] lane_a_o,
  output logic [LANE_W-1:0] lane_b_o,
  output logic              pat_active_o
);
  fmt_e              fmt;
  mode_e             mode, mode_q;
  fmt_e              fmt_q;
  logic [WIDE_W-1:0] ramp_val, word_d;
  logic [LANE_W-1:0] lane_a_d, lane_b_d;
  logic              use_code2;
  logic              run_q;

  assign fmt = fmt_e'(fmt_i);

  adc_pat_mode_sel i_mode_sel (
    .deskew_en_i (deskew_en_i),
    .sync_en_i   (sync_en_i),
    .ramp_en_i   (ramp_en_i),
    .dual_en_i   (dual_en_i),
    .single_en_i (single_en_i),
    .mode_o      (mode)
  );

  adc_pat_seq #(
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .LANE_W   (LANE_W)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .prev_mode_i (mode_q),
    .fmt_i       (fmt),
    .ramp_o      (ramp_val),
    .use_code2_o (use_code2)
  );

  adc_pat_format #(
    .CODE_W   (CODE_W),
    .NARROW_W (NARROW_W),
    .WIDE_W   (WIDE_W),
    .LANE_W   (LANE_W)
  ) i_format (
    .mode_i      (mode),
    .fmt_i       (fmt),
    .sample_i    (sample_i),
    .code1_i     (code1_i),
    .code2_i     (code2_i),
    .use_code2_i (use_code2),
    .ramp_i      (ramp_val),
    .word_o      (word_d),
    .lane_a_o    (lane_a_d),
    .lane_b_o    (lane_b_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_NONE;
      fmt_q        <= FMT_12;
      word_o       <= '0;
      lane_a_o     <= '0;
      lane_b_o     <= '0;
      pat_active_o <= 1'b0;
      run_q        <= 1'b0;
    end else begin
      mode_q       <= mode;
      fmt_q        <= fmt;
      word_o       <= word_d;
      lane_a_o     <= lane_a_d;
      lane_b_o     <= lane_b_d;
      pat_active_o <= (mode != MODE_NONE);
      run_q        <= 1'b1;
    end
  end

  function automatic logic [WIDE_W-1:0] fs_mask(fmt_e f);
    case (f)
      FMT_14:  return '1;
      FMT_D8:  return {{(WIDE_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
      default: return {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    endcase
  endfunction

  logic any_en;
  assign any_en = ramp_en_i | single_en_i | dual_en_i | deskew_en_i | sync_en_i;

  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (word_o == '0 && lane_a_o == '0 && lane_b_o == '0 && !pat_active_o));

  p_pass_14_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !$past(any_en) && $past(fmt_i) == 2'd1)
      |-> word_o == $past(sample_i[CODE_W-1 -: WIDE_W]));

  p_ramp_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RAMP && $past(mode_q) != MODE_RAMP && fmt_q != FMT_D8)
      |-> word_o == '0);

  p_ramp_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RAMP && $past(mode_q) == MODE_RAMP && fmt_q == $past(fmt_q) && fmt_q != FMT_D8)
      |-> word_o == (($past(word_o) + WIDE_W'(1)) & fs_mask(fmt_q)));

  p_dual_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DUAL && $past(mode_q) != MODE_DUAL && fmt_q == FMT_14)
      |-> word_o == $past(code1_i[CODE_W-1 -: WIDE_W]));

  p_deskew_12_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(deskew_en_i) && $past(fmt_i) == 2'd0)
      |-> word_o == WIDE_W'(12'h555));

  p_active_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> pat_active_o == $past(any_en));

  p_lane_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q != FMT_D8) |-> (lane_a_o == '0 && lane_b_o == '0));

  p_word_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_q == FMT_D8) |-> word_o == '0);
endmodule

// File: tb/test_adc_pat_gen.sv
`timescale 1ns/1ps
module test_adc_pat_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] sample = '0;
  logic [1:0]  fmt = '0;
  logic        ramp_en = 0, single_en = 0, dual_en = 0, deskew_en = 0, sync_en = 0;
  logic [15:0] code1 = '0, code2 = '0;
  logic [13:0] word;
  logic [7:0]  lane_a, lane_b;
  logic        active;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // model state
  int m_prev = 0;
  int m_ramp = 0;
  int m_ph = 0;
  int e_word = 0, e_a = 0, e_b = 0, e_act = 0;

  always #2.5 clk = ~clk;

  adc_pat_gen i_adc_pat_gen (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sample_i     (sample),
    .fmt_i        (fmt),
    .ramp_en_i    (ramp_en),
    .single_en_i  (single_en),
    .dual_en_i    (dual_en),
    .deskew_en_i  (deskew_en),
    .sync_en_i    (sync_en),
    .code1_i      (code1),
    .code2_i      (code2),
    .word_o       (word),
    .lane_a_o     (lane_a),
    .lane_b_o     (lane_b),
    .pat_active_o (active)
  );

  // reference model: advance one clock using inputs present at the edge
  task automatic model_edge();
    int mode, v, fs;
    bit d8;
    if (!rst_ni) begin
      m_prev = 0; m_ramp = 0; m_ph = 0;
      e_word = 0; e_a = 0; e_b = 0; e_act = 0;
      return;
    end
    mode = deskew_en ? 5 : sync_en ? 4 : ramp_en ? 3 : dual_en ? 2 : single_en ? 1 : 0;
    d8 = (fmt == 2);
    fs = (fmt == 1) ? 16384 : d8 ? 256 : 4096;
    e_word = 0; e_a = 0; e_b = 0;
    e_act = (mode != 0);
    case (mode)
      3: begin
        m_ramp = (m_prev == 3) ? (m_ramp + 1) % fs : 0;
        v = m_ramp;
        if (d8) begin e_a = v; e_b = v; end else e_word = v;
      end
      5: begin
        if (d8) begin e_a = 'h55; e_b = 'h55; end
        else e_word = (fmt == 1) ? 'h1555 : 'h555;
      end
      4: begin
        if (d8) begin e_a = 'hF0; e_b = 'hF0; end
        else e_word = (fmt == 1) ? 'h3F80 : 'hFC0;
      end
      default: begin
        if (mode == 2) begin
          m_ph = (m_prev == 2) ? 1 - m_ph : 0;
          v = m_ph ? int'(code2) : int'(code1);
        end else if (mode == 1) v = code1;
        else v = sample;
        if (d8) begin e_a = v / 256; e_b = v % 256; end
        else if (fmt == 1) e_word = v / 4;
        else e_word = v / 16;
      end
    endcase
    m_prev = mode;
  endtask

  task automatic compare(string req);
    checks++;
    if (word !== 14'(e_word) || lane_a !== 8'(e_a) || lane_b !== 8'(e_b) || active !== 1'(e_act)) begin
      errors++;
      $display("FAIL %s: word=%h a=%h b=%h act=%b expected word=%h a=%h b=%h act=%0d",
               req, word, lane_a, lane_b, active, 14'(e_word), 8'(e_a), 8'(e_b), e_act);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare(cur_req);
  endtask

  task automatic set_en(bit r, bit s, bit d, bit k, bit y);
    ramp_en = r; single_en = s; dual_en = d; deskew_en = k; sync_en = y;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state with inputs active
    cur_req = "R1";
    set_en(1, 0, 0, 0, 0);
    sample = 16'hBEEF;
    repeat (3) step();
    set_en(0, 0, 0, 0, 0);
    step();
    rst_ni = 1'b1;

    // R2: pass-through in every format
    cur_req = "R2";
    for (int f = 0; f < 4; f++) begin
      fmt = 2'(f);
      for (int i = 0; i < 20; i++) begin
        sample = 16'($urandom);
        step();
      end
    end

    // R3 / R4: ramp from zero and wrap, all formats
    cur_req = "R3_R4";
    fmt = 2'd0; set_en(1, 0, 0, 0, 0);
    repeat (4100) step();
    set_en(0, 0, 0, 0, 0); step();
    fmt = 2'd1; set_en(1, 0, 0, 0, 0);
    repeat (16390) step();
    set_en(0, 0, 0, 0, 0); step();
    fmt = 2'd2; set_en(1, 0, 0, 0, 0);
    repeat (300) step();
    set_en(0, 0, 0, 0, 0); step();

    // R5: single custom
    cur_req = "R5";
    for (int f = 0; f < 3; f++) begin
      fmt = 2'(f);
      set_en(0, 1, 0, 0, 0);
      for (int i = 0; i < 6; i++) begin
        code1 = 16'($urandom);
        step();
      end
    end

    // R6: dual custom
    cur_req = "R6";
    code1 = 16'hA5C3; code2 = 16'h5A3C;
    for (int f = 0; f < 3; f++) begin
      fmt = 2'(f);
      set_en(0, 0, 0, 0, 0); step();
      set_en(0, 0, 1, 0, 0);
      repeat (9) step();
    end

    // R7 deskew, R8 sync
    for (int f = 0; f < 4; f++) begin
      fmt = 2'(f);
      cur_req = "R7";
      set_en(0, 0, 0, 1, 0); repeat (3) step();
      cur_req = "R8";
      set_en(0, 0, 0, 0, 1); repeat (3) step();
    end

    // R9: priority with overlapping enables
    cur_req = "R9";
    for (int i = 0; i < 300; i++) begin
      logic [4:0] e;
      e = 5'($urandom);
      set_en(e[0], e[1], e[2], e[3], e[4]);
      fmt = 2'($urandom_range(0, 2));
      code1 = 16'($urandom); code2 = 16'($urandom); sample = 16'($urandom);
      step();
    end

    // R10: flag follows enables
    cur_req = "R10";
    set_en(0, 0, 0, 0, 0); repeat (2) step();
    set_en(0, 1, 0, 0, 0); repeat (2) step();
    set_en(0, 0, 0, 0, 0); step();

    // R11: restart after a one-cycle gap and after preemption
    cur_req = "R11";
    fmt = 2'd1;
    set_en(1, 0, 0, 0, 0); repeat (7) step();
    set_en(0, 0, 0, 0, 0); step();
    set_en(1, 0, 0, 0, 0); repeat (5) step();
    set_en(1, 0, 0, 1, 0); step();
    set_en(1, 0, 0, 0, 0); repeat (4) step();
    set_en(0, 0, 1, 0, 0); repeat (3) step();
    set_en(0, 0, 1, 0, 1); step();
    set_en(0, 0, 1, 0, 0); repeat (4) step();
    set_en(0, 1, 0, 0, 0); step();
    set_en(0, 0, 1, 0, 0); repeat (3) step();

    // R12 plus mixed traffic, format changes mid-pattern
    cur_req = "R12";
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        logic [4:0] e;
        e = 5'($urandom);
        set_en(e[0], e[1], e[2], e[3], e[4]);
      end
      if ($urandom_range(0, 31) == 0) fmt = 2'($urandom);
      sample = 16'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        code1 = 16'($urandom); code2 = 16'($urandom);
      end
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule